// File: doc/BRIEF.md
# Framed PCM Serial Port with Load Strobe

This block is the serial edge of a two-direction voice processor that runs once per 8 kHz frame. Two PCM input lines, send-in and receive-in, each deliver one 8-bit sample per frame. Two output lines, send-out and receive-out, each return one 8-bit sample in the same slot. A frame sync pulse and a bit clock frame all four lines.

Once both input bytes have been captured, the port raises a load strobe. The strobe is fed back to start the processing for that frame. The output bytes come from holding registers that the processing logic writes. Each output line drives only during its 8-bit slot, and output-enable signals are produced for the pad cells.

A separate generator divides the master clock down to a bit clock and a frame sync. Board logic may route these into the port's bit-clock and sync inputs. All port inputs are sampled by the master clock through two-stage synchronizers, and the port acts on the detected bit-clock edges.

The frame state machine has four states:
- HUNT: after reset or power-down, no sync seen yet.
- XFER: shifting a byte.
- STROBE: both bytes stored, strobe high.
- GAP: idle slots until the next sync.

Its transitions are:
- START: a rising bit-clock edge with sync high, from any state, goes to XFER.
- DONE: the eighth falling edge in XFER goes to STROBE.
- RETIRE: the next falling edge in STROBE goes to GAP.
- QUIESCE: reset or sleep goes to HUNT.

Top module: `pcm_frame_port`

## Requirements
- R1: Input bits are sampled on falling bit-clock edges, MSB first. The first sampled bit is bit 7, taken in the bit-clock period in which sync is high. The two captured bytes appear on the receive-byte ports.
- R2: Output bits change after rising bit-clock edges, MSB first. Bit 7 is driven in the sync period. The holding bytes are latched at frame start, so changing them mid-frame has no effect on the byte being sent.
- R3: Both output enables are high from the sync rising edge until the rising edge that follows bit 0. They are low in all other periods.
- R4: The load strobe rises after the eighth falling edge of a frame and stays high until the next falling edge, which is one bit-clock period. The captured bytes are valid while it is high.
- R5: A sync pulse arriving mid-byte restarts the bit count and reloads the output shifters. Only the restarted byte is captured, and no strobe is produced for the partial byte.
- R6: The generated bit clock has a period of DIV master cycles (75 by default), with DIV-DIV/2 of them high. The generated sync is high for exactly one bit-clock period out of every SLOTS (32) periods, and it rises together with the bit clock.
- R7: Reset or sleep forces both output enables and the strobe low, and returns the state machine to HUNT. Sleep holds the generated bit clock and sync low.
- R8: Serial input bits arriving in slots after the strobe, with no sync, are ignored: the receive bytes keep their values and no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous reset, active high |
| sleep | input | 1 | power-down hold, active high |
| bclk_in | input | 1 | serial bit clock |
| sync_in | input | 1 | frame sync, one bit period wide |
| s_ser_in | input | 1 | send-in serial data |
| r_ser_in | input | 1 | receive-in serial data |
| s_hold | input | W | send-out holding byte |
| r_hold | input | W | receive-out holding byte |
| s_ser_out | output | 1 | send-out serial data |
| s_out_en | output | 1 | send-out drive enable |
| r_ser_out | output | 1 | receive-out serial data |
| r_out_en | output | 1 | receive-out drive enable |
| s_rx_byte | output | W | captured send-in byte |
| r_rx_byte | output | W | captured receive-in byte |
| load_stb | output | 1 | load strobe that starts processing |
| gen_bclk | output | 1 | generated bit clock |
| gen_sync | output | 1 | generated frame sync |

## Verification
Each bit-clock edge reaches the state registers 2.5 master cycles after the bench drives it: two synchronizer stages plus one register. The bench therefore holds each bit-clock phase for 8 master cycles and samples only at the last negative master edge of a phase. An output bit or enable change caused by a rising edge is read late in that same high phase. The strobe and captured bytes, caused by the eighth falling edge, are read late in the following high phase, one slot after the last data bit. The clock generator is measured directly: rise-to-rise and high-time cycle counts are compared with DIV and DIV-DIV/2, and with SLOTS*DIV and DIV for the sync.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_XFER   = 2'd1,
        ST_STROBE = 2'd2,
        ST_GAP    = 2'd3
    } port_state_t;
endpackage

// File: rtl/pcm_clkgen.sv
module pcm_clkgen #(
    parameter int DIV   = 75,
    parameter int SLOTS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep,
    output logic gen_bclk,
    output logic gen_sync
);
    localparam int CW   = $clog2(DIV);
    localparam int SW   = $clog2(SLOTS);
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;
    logic [SW-1:0] slot;

    always_ff @(posedge clk) begin
        if (rst || sleep) begin
            cnt  <= '0;
            slot <= SW'(SLOTS - 1);
        end else begin
            cnt <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
            if (cnt == CW'(HALF - 1))
                slot <= (slot == SW'(SLOTS - 1)) ? '0 : slot + 1'b1;
        end
    end

    assign gen_bclk = !sleep && (cnt >= CW'(HALF));
    assign gen_sync = !sleep && (slot == '0);

    // R6: divider never leaves its range
    p_div_range_r6: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(DIV));
    // R6: sync starts together with a bit-clock rise
    p_sync_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(gen_sync) |-> $rose(gen_bclk));
endmodule

// File: rtl/pcm_sampler.sv
module pcm_sampler #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         edge_in,
    input  logic [N-1:0] dat_in,
    output logic         rise,
    output logic         fall,
    output logic [N-1:0] dat_q
);
    logic [2:0]   e_sh;
    logic [N-1:0] d1;

    always_ff @(posedge clk) begin
        if (rst) begin
            e_sh  <= '0;
            d1    <= '0;
            dat_q <= '0;
        end else begin
            e_sh  <= {e_sh[1:0], edge_in};
            d1    <= dat_in;
            dat_q <= d1;
        end
    end

    assign rise = e_sh[1] && !e_sh[2];
    assign fall = !e_sh[1] && e_sh[2];
endmodule

// File: rtl/pcm_frame_fsm.sv
module pcm_frame_fsm
    import pcm_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sleep,
    input  logic         rise,
    input  logic         fall,
    input  logic         sync_lvl,
    input  logic         s_bit,
    input  logic         r_bit,
    input  logic [W-1:0] hold_s,
    input  logic [W-1:0] hold_r,
    output logic [W-1:0] rx_s,
    output logic [W-1:0] rx_r,
    output logic         s_out,
    output logic         r_out,
    output logic         oe,
    output logic         stb
);
    localparam int BW = $clog2(W);

    port_state_t   state, nxt;
    logic [BW-1:0] bit_cnt;
    logic [W-1:0]  sh_s, sh_r, in_s, in_r;
    logic          start, last_bit;

    assign start    = rise && sync_lvl;
    assign last_bit = (bit_cnt == BW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst || sleep) state <= ST_HUNT;
        else              state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (start) begin
            nxt = ST_XFER;
        end else begin
            unique case (state)
                ST_XFER:   if (fall && last_bit) nxt = ST_STROBE;
                ST_STROBE: if (fall) nxt = ST_GAP;
                ST_HUNT:   nxt = ST_HUNT;
                ST_GAP:    nxt = ST_GAP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sleep) begin
            bit_cnt <= '0;
            sh_s <= '0;  sh_r <= '0;
            in_s <= '0;  in_r <= '0;
            oe   <= 1'b0;
            if (rst) begin
                rx_s <= '0;
                rx_r <= '0;
            end
        end else if (start) begin
            sh_s    <= hold_s;
            sh_r    <= hold_r;
            oe      <= 1'b1;
            bit_cnt <= '0;
        end else begin
            if (rise && state == ST_XFER) begin
                sh_s <= {sh_s[W-2:0], 1'b0};
                sh_r <= {sh_r[W-2:0], 1'b0};
            end
            if (rise && state == ST_STROBE)
                oe <= 1'b0;
            if (fall && state == ST_XFER) begin
                in_s    <= {in_s[W-2:0], s_bit};
                in_r    <= {in_r[W-2:0], r_bit};
                bit_cnt <= bit_cnt + 1'b1;
                if (last_bit) begin
                    rx_s <= {in_s[W-2:0], s_bit};
                    rx_r <= {in_r[W-2:0], r_bit};
                end
            end
        end
    end

    always_comb begin
        stb   = (state == ST_STROBE);
        s_out = sh_s[W-1];
        r_out = sh_r[W-1];
    end

    // R4: strobe begins only on a detected falling edge
    p_strobe_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(stb) |-> $past(fall));
    // R3: enables drop only after a rising edge or sleep
    p_oe_release_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(oe) |-> ($past(rise) || $past(sleep)));
    // R5: a sync edge always (re)starts a byte
    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (start && !sleep) |=> (oe && state == ST_XFER));
endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port #(
    parameter int W     = 8,
    parameter int DIV   = 75,
    parameter int SLOTS = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sleep,
    input  logic         bclk_in,
    input  logic         sync_in,
    input  logic         s_ser_in,
    input  logic         r_ser_in,
    input  logic [W-1:0] s_hold,
    input  logic [W-1:0] r_hold,
    output logic         s_ser_out,
    output logic         s_out_en,
    output logic         r_ser_out,
    output logic         r_out_en,
    output logic [W-1:0] s_rx_byte,
    output logic [W-1:0] r_rx_byte,
    output logic         load_stb,
    output logic         gen_bclk,
    output logic         gen_sync
);
    logic       rise, fall, oe;
    logic [2:0] lv;

    pcm_clkgen #(.DIV(DIV), .SLOTS(SLOTS)) u_gen (
        .clk(clk), .rst(rst), .sleep(sleep),
        .gen_bclk(gen_bclk), .gen_sync(gen_sync)
    );

    pcm_sampler #(.N(3)) u_smp (
        .clk(clk), .rst(rst), .edge_in(bclk_in),
        .dat_in({r_ser_in, s_ser_in, sync_in}),
        .rise(rise), .fall(fall), .dat_q(lv)
    );

    pcm_frame_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst(rst), .sleep(sleep),
        .rise(rise), .fall(fall), .sync_lvl(lv[0]),
        .s_bit(lv[1]), .r_bit(lv[2]),
        .hold_s(s_hold), .hold_r(r_hold),
        .rx_s(s_rx_byte), .rx_r(r_rx_byte),
        .s_out(s_ser_out), .r_out(r_ser_out),
        .oe(oe), .stb(load_stb)
    );

    assign s_out_en = oe;
    assign r_out_en = oe;

    // R7: sleep quiets the port on the following cycle
    p_sleep_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        sleep |=> (!s_out_en && !r_out_en && !load_stb));
endmodule

// File: tb/sim_pcm_frame_port.sv
module sim_pcm_frame_port;
    localparam int W = 8, DIV = 75, SLOTS = 32;

    logic clk = 0, rst = 1, sleep = 0;
    logic bclk_in = 0, sync_in = 0, s_ser_in = 0, r_ser_in = 0;
    logic [W-1:0] s_hold = 0, r_hold = 0;
    logic s_ser_out, s_out_en, r_ser_out, r_out_en, load_stb, gen_bclk, gen_sync;
    logic [W-1:0] s_rx_byte, r_rx_byte;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pcm_frame_port #(.W(W), .DIV(DIV), .SLOTS(SLOTS)) u0 (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int k = 0; k < 150000; k++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // one bit-clock slot: 8 cycles high then 8 low; samples end of high phase
    task automatic slot(input logic sy, input logic sb, input logic rb,
                        output logic so, output logic ro, output logic oe, output logic st);
        @(negedge clk);
        bclk_in = 1; sync_in = sy; s_ser_in = sb; r_ser_in = rb;
        repeat (7) @(negedge clk);
        so = s_ser_out; ro = r_ser_out; oe = s_out_en && r_out_en; st = load_stb;
        @(negedge clk);
        bclk_in = 0;
        repeat (7) @(negedge clk);
    endtask

    task automatic do_frame(input logic [W-1:0] sb, input logic [W-1:0] rb,
                            input logic [W-1:0] hs, input logic [W-1:0] hr, input int n);
        logic so, ro, oe, st;
        int bad_o = 0, bad_e = 0, bad_q = 0;
        s_hold = hs; r_hold = hr;
        for (int i = 0; i < n; i++) begin
            if (i == 3) begin s_hold = ~hs; r_hold = ~hr; end
            slot(i == 0, (i < W) ? sb[W-1-i] : i[0], (i < W) ? rb[W-1-i] : ~i[0], so, ro, oe, st);
            if (i < W) begin
                if (so != hs[W-1-i] || ro != hr[W-1-i]) bad_o++;
                if (!oe || st) bad_e++;
            end else if (i == W) begin
                chk("R4 strobe high one slot after bit 0", st, 1);
                chk("R3 enables released after bit 0", oe, 0);
                chk("R1 send-in byte captured", s_rx_byte, sb);
                chk("R1 receive-in byte captured", r_rx_byte, rb);
            end else begin
                if (i == W + 1) chk("R4 strobe lasts one bit period", st, 0);
                if (oe || st) bad_q++;
                if (s_rx_byte != sb || r_rx_byte != rb) bad_q++;
            end
        end
        chk("R2 output bits MSB first, latched at frame start", bad_o, 0);
        chk("R3 enables high through the data slot", bad_e, 0);
        if (n > W + 2) chk("R8 bits outside the slot ignored", bad_q, 0);
    endtask

    task automatic measure(input bit w, output int per, output int hi);
        logic p, n;
        per = 0; hi = 1;
        p = w ? gen_sync : gen_bclk;
        for (int k = 0; k < 10000; k++) begin
            @(negedge clk); n = w ? gen_sync : gen_bclk;
            if (n && !p) break;
            p = n;
        end
        p = 1;
        for (int k = 0; k < 10000; k++) begin
            @(negedge clk); n = w ? gen_sync : gen_bclk; per++;
            if (n && !p) break;
            if (n) hi++;
            p = n;
        end
    endtask

    initial begin
        int per, hi;
        logic so, ro, oe, st;
        repeat (5) @(negedge clk);
        chk("R7 reset: enables low", s_out_en || r_out_en, 0);
        chk("R7 reset: strobe low", load_stb, 0);
        rst = 0;
        @(negedge clk);
        chk("R7 after reset: captured bytes zero", {s_rx_byte, r_rx_byte}, 0);

        measure(0, per, hi);
        chk("R6 bit clock period", per, DIV);
        chk("R6 bit clock high time", hi, DIV - DIV / 2);
        measure(1, per, hi);
        chk("R6 sync period", per, SLOTS * DIV);
        chk("R6 sync width", hi, DIV);

        do_frame(8'hA5, 8'h3C, 8'h96, 8'h0F, 32);
        do_frame(8'h00, 8'hFF, 8'hFF, 8'h00, 12);
        do_frame(8'h80, 8'h01, 8'h01, 8'h80, 12);
        for (int k = 0; k < 16; k++)
            do_frame(W'(k * 37 + 11), W'(k * 91 + 5), W'(k * 53 + 200), W'(k * 17 + 3), 11);

        // R5: restart mid byte, partial byte 0xFF replaced by 0x5A / 0xC3
        slot(1, 1, 1, so, ro, oe, st);
        slot(0, 1, 1, so, ro, oe, st);
        slot(0, 1, 1, so, ro, oe, st);
        chk("R5 no strobe during partial byte", st, 0);
        do_frame(8'h5A, 8'hC3, 8'h69, 8'hE1, 12);
        chk("R5 restarted byte captured", s_rx_byte, 8'h5A);

        // R8: long run of slots without sync
        for (int i = 0; i < 20; i++) begin
            slot(0, i[0], i[1], so, ro, oe, st);
            if (st || oe) chk("R8 no strobe or drive without sync", 1, 0);
        end
        chk("R8 send byte kept without sync", s_rx_byte, 8'h5A);
        chk("R8 receive byte kept without sync", r_rx_byte, 8'hC3);

        // R7: sleep in mid frame
        s_hold = 8'hFF;
        slot(1, 0, 0, so, ro, oe, st);
        chk("R7 frame started before sleep", oe, 1);
        @(negedge clk); sleep = 1;
        repeat (3) @(negedge clk);
        chk("R7 sleep releases enables", s_out_en || r_out_en, 0);
        chk("R7 sleep holds generated clocks low", gen_bclk || gen_sync, 0);
        repeat (100) @(negedge clk);
        chk("R7 generated clocks stay low in sleep", gen_bclk || gen_sync, 0);
        sleep = 0;
        @(negedge clk); bclk_in = 0;
        repeat (8) @(negedge clk);
        do_frame(8'h33, 8'hCC, 8'h5A, 8'hA5, 12);
        finish_run();
    end
endmodule